// File: doc/BRIEF.md
# Converter Sync Sequencer

This block decides when a decimating converter's digital filter may begin gathering samples. A shared active-low sync request, common to every converter on one master clock, is polled on the falling edge of that clock. While the request is seen low, the block holds the filter sequencer in reset with its count at zero. On the first falling edge that sees the request high again, the block releases the filter. It then restarts the output-frame timing from that edge, so every converter that shares the request emits its frame strobe on the same cycle.

After each release, a filter-settled flag stays clear for a configurable number of output frames. The flag appears as the top bit of a status byte that accompanies each result. The decimation setting, and with it the frame length, is captured at release and held until the next sync. A request that stays low for too few falling edges is not honoured: the block raises a one-cycle violation pulse and keeps the filter held until a valid sync arrives. All state changes on the falling master-clock edge. No data flows through the block, so it has no valid/ready interface. The frame strobe is a plain one-cycle pulse with no back-pressure.

Top module: `sync_seq`

## Requirements
- R1: The sync request is looked at only on falling master-clock edges. A low that starts and ends between two falling edges has no effect on any output.
- R2: On the falling edge after one that finds sync_n low, filt_rst is 1, seq_cnt is 0 and settled is 0.
- R3: filt_rst stays 1 for as long as every falling edge finds sync_n low. The first falling edge that finds it high, after a valid low run, clears filt_rst with seq_cnt at 0. seq_cnt then rises by one per falling edge.
- R4: A low run seen on fewer than 4 consecutive falling edges raises sync_err for exactly one cycle at the releasing edge and leaves filt_rst at 1 until a later valid sync. A run of exactly 4 edges is honoured.
- R5: While running, the frame length is P = 4 << dec. frame_stb is 1 exactly when seq_cnt equals P-1, and seq_cnt wraps to 0 on the following edge.
- R6: settled is 0 while held. After release, it becomes 1 on the edge that ends the N-th frame, where N is settle_cfg (N = 0 means at release). It always equals bit 7 of status_byte.
- R7: dec_sel is captured at the releasing edge. Changes made while running alter neither the frame length nor status_byte[1:0], which report the captured value.
- R8: While rst_n is low, filt_rst is 1, settled is 0 and seq_cnt is 0. The first falling edge after reset that finds sync_n high releases the filter and loads settle_cfg.
- R9: settle_cfg is taken only at the releasing edge. Later changes do not move the settle point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Shared active-low sync request |
| dec_sel | input | 2 | Decimation select; frame length 4 << dec_sel |
| settle_cfg | input | 4 | Settle interval in output frames |
| filt_rst | output | 1 | Holds the filter sequencer in reset |
| seq_cnt | output | 5 | Filter sequencer count within the frame |
| frame_stb | output | 1 | One-cycle strobe on the last cycle of each frame |
| settled | output | 1 | Filter output is valid |
| status_byte | output | 8 | Result status: bit 7 settled, bits 1:0 captured decimation |
| sync_err | output | 1 | One-cycle pulse for a too-short sync request |

## Verification
The properties assume sync_n changes only around the rising edge, well clear of the falling decision edge. The bench drives sync_n just after rising edges, with one exception: a glitch that begins and ends between two falling edges. That glitch still never changes at a falling edge. The properties also take dec_sel and settle_cfg to be meaningful only at release. The stimulus changes them freely while the block is running, to show they are ignored. The bench samples every output one nanosecond after each rising edge, halfway between decision edges.

// File: rtl/sync_seq_pkg.sv
package sync_seq_pkg;

  typedef enum logic [1:0] {
    SQ_BOOT  = 2'd0,
    SQ_LOW   = 2'd1,
    SQ_FAULT = 2'd2,
    SQ_RUN   = 2'd3
  } sq_state_e;

endpackage

// File: rtl/sync_seq_detect.sv
module sync_seq_detect
  import sync_seq_pkg::*;
#(
  parameter int MIN_LOW = 4
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic sync_n,
  output logic held,
  output logic hold_nxt,
  output logic err_pulse
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam logic [LW-1:0] LMAX = LW'(MIN_LOW);

  sq_state_e st_q, st_d;
  logic [LW-1:0] low_q, low_d;
  logic err_d;

  always_comb begin
    st_d  = st_q;
    low_d = low_q;
    err_d = 1'b0;
    if (!sync_n) begin
      st_d  = SQ_LOW;
      if (st_q == SQ_LOW) begin
        low_d = (low_q == LMAX) ? low_q : low_q + 1'b1;
      end else begin
        low_d = LW'(1);
      end
    end else begin
      unique case (st_q)
        SQ_BOOT:  st_d = SQ_RUN;
        SQ_LOW: begin
          if (low_q >= LMAX) begin
            st_d = SQ_RUN;
          end else begin
            st_d  = SQ_FAULT;
            err_d = 1'b1;
          end
        end
        SQ_FAULT: st_d = SQ_FAULT;
        default:  st_d = SQ_RUN;
      endcase
    end
  end

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_BOOT;
      low_q     <= '0;
      err_pulse <= 1'b0;
    end else begin
      st_q      <= st_d;
      low_q     <= low_d;
      err_pulse <= err_d;
    end
  end

  assign held     = (st_q != SQ_RUN);
  assign hold_nxt = (st_d != SQ_RUN);

endmodule

// File: rtl/sync_seq_timer.sv
module sync_seq_timer #(
  parameter int BASE_DIV = 4,
  parameter int DEC_W    = 2,
  parameter int CNT_W    = 5
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             held,
  input  logic             hold_nxt,
  input  logic [DEC_W-1:0] dec_sel,
  output logic [CNT_W-1:0] seq_cnt,
  output logic [DEC_W-1:0] dec_q,
  output logic             frame_stb
);
  localparam logic [CNT_W:0] BASE = (CNT_W+1)'(BASE_DIV);

  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] last_cnt;

  assign period    = BASE << dec_q;
  assign last_cnt  = CNT_W'(period - 1'b1);
  assign frame_stb = !held && (seq_cnt == last_cnt);

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      seq_cnt <= '0;
      dec_q   <= '0;
    end else if (held) begin
      seq_cnt <= '0;
      dec_q   <= dec_sel;
    end else if (hold_nxt || frame_stb) begin
      seq_cnt <= '0;
    end else begin
      seq_cnt <= seq_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sync_seq_settle.sv
module sync_seq_settle #(
  parameter int SET_W = 4
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             held,
  input  logic             hold_nxt,
  input  logic             frame_stb,
  input  logic [SET_W-1:0] settle_cfg,
  output logic             settled
);
  logic [SET_W-1:0] left_q;

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (held) begin
      left_q <= settle_cfg;
    end else if (!hold_nxt && frame_stb && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign settled = !held && (left_q == '0);

endmodule

// File: rtl/sync_seq.sv
module sync_seq #(
  parameter int BASE_DIV = 4,
  parameter int DEC_W    = 2,
  parameter int SET_W    = 4,
  parameter int MIN_LOW  = 4,
  parameter int CNT_W    = $clog2(BASE_DIV << ((1 << DEC_W) - 1))
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic [DEC_W-1:0] dec_sel,
  input  logic [SET_W-1:0] settle_cfg,
  output logic             filt_rst,
  output logic [CNT_W-1:0] seq_cnt,
  output logic             frame_stb,
  output logic             settled,
  output logic [7:0]       status_byte,
  output logic             sync_err
);
  localparam int PAD_W = 7 - DEC_W;

  logic             held, hold_nxt;
  logic [DEC_W-1:0] dec_q;

  sync_seq_detect #(.MIN_LOW(MIN_LOW)) u_detect (
    .mclk(mclk), .rst_n(rst_n), .sync_n(sync_n),
    .held(held), .hold_nxt(hold_nxt), .err_pulse(sync_err)
  );

  sync_seq_timer #(.BASE_DIV(BASE_DIV), .DEC_W(DEC_W), .CNT_W(CNT_W)) u_timer (
    .mclk(mclk), .rst_n(rst_n), .held(held), .hold_nxt(hold_nxt),
    .dec_sel(dec_sel), .seq_cnt(seq_cnt), .dec_q(dec_q), .frame_stb(frame_stb)
  );

  sync_seq_settle #(.SET_W(SET_W)) u_settle (
    .mclk(mclk), .rst_n(rst_n), .held(held), .hold_nxt(hold_nxt),
    .frame_stb(frame_stb), .settle_cfg(settle_cfg), .settled(settled)
  );

  assign filt_rst    = held;
  assign status_byte = {settled, {PAD_W{1'b0}}, dec_q};

endmodule

// File: rtl/sync_seq_checker.sv
module sync_seq_checker #(
  parameter int CNT_W = 5
) (
  input logic             mclk,
  input logic             rst_n,
  input logic             sync_n,
  input logic             filt_rst,
  input logic [CNT_W-1:0] seq_cnt,
  input logic             frame_stb,
  input logic             settled,
  input logic [7:0]       status_byte,
  input logic             sync_err
);

  assert_hold_on_low_R2: assert property (@(negedge mclk) disable iff (!rst_n)
    !sync_n |=> (filt_rst && seq_cnt == '0 && !settled));

  assert_keep_running_R3: assert property (@(negedge mclk) disable iff (!rst_n)
    (!filt_rst && sync_n) |=> !filt_rst);

  assert_count_step_R3: assert property (@(negedge mclk) disable iff (!rst_n)
    (!filt_rst && sync_n && !frame_stb) |=> (seq_cnt == CNT_W'($past(seq_cnt) + 1'b1)));

  assert_fault_held_R4: assert property (@(negedge mclk) disable iff (!rst_n)
    sync_err |-> filt_rst);

  assert_strobe_running_R5: assert property (@(negedge mclk) disable iff (!rst_n)
    frame_stb |-> !filt_rst);

  assert_wrap_after_strobe_R5: assert property (@(negedge mclk) disable iff (!rst_n)
    frame_stb |=> (seq_cnt == '0));

  assert_unsettled_held_R6: assert property (@(negedge mclk) disable iff (!rst_n)
    filt_rst |-> !settled);

  assert_settled_drop_R6: assert property (@(negedge mclk) disable iff (!rst_n)
    $fell(settled) |-> filt_rst);

  assert_dec_stable_R7: assert property (@(negedge mclk) disable iff (!rst_n)
    (!filt_rst && sync_n) |=> $stable(status_byte[1:0]));

endmodule

bind sync_seq sync_seq_checker u_sync_seq_checker (
  .mclk(mclk), .rst_n(rst_n), .sync_n(sync_n), .filt_rst(filt_rst),
  .seq_cnt(seq_cnt), .frame_stb(frame_stb), .settled(settled),
  .status_byte(status_byte), .sync_err(sync_err)
);

// File: tb/sync_seq_bench.sv
module sync_seq_bench;
  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b1;
  logic [1:0] dec_sel = 2'd0;
  logic [3:0] settle_cfg = 4'd0;
  logic       filt_rst, frame_stb, settled, sync_err;
  logic [4:0] seq_cnt;
  logic [7:0] status_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 mclk = ~mclk;

  sync_seq u_sync_seq (
    .mclk(mclk), .rst_n(rst_n), .sync_n(sync_n), .dec_sel(dec_sel),
    .settle_cfg(settle_cfg), .filt_rst(filt_rst), .seq_cnt(seq_cnt),
    .frame_stb(frame_stb), .settled(settled), .status_byte(status_byte),
    .sync_err(sync_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge mclk);
    #1;
  endtask

  task automatic sync_pulse(input int nlow, input int cfg, input int dec);
    settle_cfg = 4'(cfg);
    dec_sel    = 2'(dec);
    sync_n     = 1'b0;
    repeat (nlow) step();
    sync_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    step();
    chk(filt_rst == 1'b1, "R8 held in reset", filt_rst, 1);
    chk(settled == 1'b0, "R8 unsettled in reset", settled, 0);
    chk(seq_cnt == 5'd0, "R8 count zero in reset", seq_cnt, 0);
    rst_n = 1'b1;
    step();
    chk(filt_rst == 1'b0, "R8 release after reset", filt_rst, 0);
    chk(settled == 1'b1, "R8 settle_cfg 0 loaded", settled, 1);
  endtask

  task automatic t_hold();
    settle_cfg = 4'd0;
    sync_n = 1'b0;
    step();
    chk(filt_rst == 1'b1, "R2 held after low", filt_rst, 1);
    chk(seq_cnt == 5'd0, "R2 count zero", seq_cnt, 0);
    chk(settled == 1'b0, "R2 settled cleared", settled, 0);
    repeat (5) step();
    chk(filt_rst == 1'b1, "R3 still held", filt_rst, 1);
    sync_n = 1'b1;
    step();
    chk(filt_rst == 1'b0, "R3 released", filt_rst, 0);
    chk(seq_cnt == 5'd0, "R3 count zero at release", seq_cnt, 0);
    step();
    chk(seq_cnt == 5'd1, "R3 count steps", seq_cnt, 1);
  endtask

  task automatic t_strobe(input int dec);
    int p;
    p = 4 << dec;
    sync_pulse(4, 0, dec);
    for (int k = 0; k <= 2 * p; k++) begin
      chk(frame_stb == ((k % p) == p - 1), "R5 strobe position", frame_stb, int'((k % p) == p - 1));
      chk(seq_cnt == 5'(k % p), "R5 count wrap", seq_cnt, k % p);
      step();
    end
  endtask

  task automatic t_short(input int nlow);
    sync_pulse(nlow, 0, 0);
    chk(sync_err == 1'b1, "R4 violation pulse", sync_err, 1);
    chk(filt_rst == 1'b1, "R4 short not honoured", filt_rst, 1);
    step();
    chk(sync_err == 1'b0, "R4 pulse one cycle", sync_err, 0);
    repeat (10) step();
    chk(filt_rst == 1'b1, "R4 stays held", filt_rst, 1);
    chk(frame_stb == 1'b0, "R4 no strobe held", frame_stb, 0);
    sync_pulse(4, 0, 0);
    chk(filt_rst == 1'b0, "R4 four lows honoured", filt_rst, 0);
    chk(sync_err == 1'b0, "R4 no violation on four", sync_err, 0);
  endtask

  task automatic t_settle();
    sync_pulse(4, 3, 0);
    settle_cfg = 4'd0;
    chk(settled == 1'b0, "R6 cleared after release", settled, 0);
    repeat (5) step();
    chk(settled == 1'b0, "R9 later cfg ignored", settled, 0);
    repeat (6) step();
    chk(settled == 1'b0, "R6 not before third frame end", settled, 0);
    chk(status_byte[7] == 1'b0, "R6 status bit7 low", status_byte[7], 0);
    step();
    chk(settled == 1'b1, "R6 set after third frame", settled, 1);
    chk(status_byte[7] == 1'b1, "R6 status bit7 high", status_byte[7], 1);
    sync_n = 1'b0;
    step();
    chk(settled == 1'b0, "R6 resync clears settled", settled, 0);
    sync_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_dec_fixed();
    sync_pulse(4, 0, 1);
    dec_sel = 2'd3;
    for (int k = 0; k < 16; k++) begin
      chk(frame_stb == ((k % 8) == 7), "R7 length kept", frame_stb, int'((k % 8) == 7));
      step();
    end
    chk(status_byte[1:0] == 2'd1, "R7 captured dec", status_byte[1:0], 1);
  endtask

  task automatic t_glitch();
    sync_pulse(4, 0, 0);
    step();
    sync_n = 1'b0;
    #2;
    sync_n = 1'b1;
    step();
    chk(filt_rst == 1'b0, "R1 glitch ignored", filt_rst, 0);
    chk(seq_cnt == 5'd2, "R1 count undisturbed", seq_cnt, 2);
    chk(settled == 1'b1, "R1 settled kept", settled, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hold();
    t_strobe(0);
    t_strobe(2);
    t_short(2);
    t_short(3);
    t_settle();
    t_dec_fixed();
    t_glitch();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule